// File: doc/BRIEF.md
# Serial DAC Host Command Sequencer

This block sits on the host side of a quad 8-bit serial DAC. It turns requests from a one-at-a-time command port into activity on three lines: a serial clock, a serial data line and a load-enable line. A request is one of four operations:

- a channel write, carrying a channel number and an 8-bit code;
- a control write, carrying per-channel range bits, per-channel shutdown-inhibit bits, an activate bit and a mode bit;
- a resync, which sends twelve zero bits;
- a commit.

Each write or resync becomes a 12-bit frame. The frame goes out MSB first, and the DAC samples every bit on a falling serial-clock edge. Frames sent back to back share a single enable window. The commit drops the enable line, which latches everything sent in that window.

All edge spacing is counted in system clocks. The counts are derived at elaboration from a system clock period parameter and minimum times in nanoseconds, each rounded up to whole cycles. With the default 8 ns period the counts are:

| Interval | Cycles |
|---|---|
| Serial clock high phase | 50 |
| Serial clock low phase between bits | 75 |
| Enable lead before the first clock rise | 13 |
| Tail after the last falling edge | 75 |
| Minimum enable-low gap | 25 |

The sequencer is a seven-state machine:

- `ST_IDLE`: enable is low and the block is ready.
- `ST_LEAD`: enable is high before the first clock rise.
- `ST_HIGH`: the serial clock is high.
- `ST_LOW`: the serial clock is low between bits.
- `ST_TAIL`: the wait after the last falling edge of a frame.
- `ST_WINDOW`: enable is high and the block is ready for more frames or a commit.
- `ST_GAP`: enable is held low after a commit.

Transitions:

- `ST_IDLE` goes to `ST_LEAD` on any accepted request.
- `ST_LEAD` goes to `ST_HIGH` when its count expires, or to `ST_GAP` if the request was a bare commit.
- `ST_HIGH` goes to `ST_LOW` after a bit that is not the last one, or to `ST_TAIL` after the twelfth bit.
- `ST_LOW` goes back to `ST_HIGH`.
- `ST_TAIL` goes to `ST_WINDOW`.
- `ST_WINDOW` goes to `ST_HIGH` on a frame request, or to `ST_GAP` on a commit.
- `ST_GAP` goes to `ST_IDLE`.

Top module: `dac_serial_host`

## Requirements
- R1: After reset, `dac_en`, `dac_sclk` and `dac_sdata` are 0 and `cmd_ready` is 1.
- R2: A channel write (op 0) sends the frame whose bits are laid out as follows, and frame bit 11 goes out first, sampled on the falling `dac_sclk` edge:
  - bit 11 = 0;
  - bits 10:9 = channel;
  - bits 8:1 = code;
  - bit 0 = 0.
- R3: A control write (op 1) sends a frame whose bits are laid out as follows:
  - bit 11 = 1;
  - bits 10,9,8,7 = range bit of channel 0,1,2,3;
  - bits 6,5,4,3 = inhibit bit of channel 0,1,2,3;
  - bit 2 = activate;
  - bit 1 = mode;
  - bit 0 = 0.
- R4: A resync (op 2) sends a frame of twelve zero bits.
- R5: Timing of the serial clock and data line:
  - `dac_sclk` stays high for exactly HIGH_CYC (default 50) cycles per bit;
  - between bits of one frame it stays low for exactly LOW_CYC (default 75) cycles;
  - `dac_sdata` changes only while `dac_sclk` is high, exactly one cycle after it rises.
- R6: The first `dac_sclk` rise of a window comes exactly LEAD_CYC (default 13) cycles after `dac_en` rises. `dac_en` falls at least TAIL_CYC (default 75) cycles after the last falling clock edge.
- R7: Any number of frames sent before a commit share one enable window. `dac_en` falls only on a commit, only at a frame boundary, and only while `dac_sclk` is low. `dac_sclk` is high only while `dac_en` is high.
- R8: A commit (op 3) accepted while the enable line is low produces an enable pulse of exactly LEAD_CYC cycles with no clock edges.
- R9: After every falling edge of `dac_en`, it stays low for at least GAP_CYC (default 25) cycles.
- R10: `cmd_ready` is 1 only while idle or waiting inside a window. It is 0 on the cycle after a request is accepted. A request held while `cmd_ready` is 0 has no effect on the frames sent.
- R11: Every cycle count is the ceiling of the matching time divided by the clock period. The high phase is also at least the setup count plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request accepted when high together with cmd_valid |
| cmd_op | input | 2 | 0 channel write, 1 control write, 2 resync, 3 commit |
| cmd_chan | input | 2 | Channel number for a channel write |
| cmd_code | input | 8 | Code for a channel write |
| cmd_range | input | 4 | Range bit per channel for a control write |
| cmd_inhibit | input | 4 | Shutdown-inhibit bit per channel for a control write |
| cmd_act | input | 1 | Activate bit for a control write |
| cmd_mode | input | 1 | Mode bit for a control write |
| dac_sclk | output | 1 | Serial clock to the DAC, idles low |
| dac_sdata | output | 1 | Serial data to the DAC |
| dac_en | output | 1 | Load enable to the DAC; its falling edge commits |

## Verification
A wrong state register or mis-loaded timer shows at the ports within one bit time, about 125 cycles: a high or low phase of the wrong length, a data change outside the clock-high phase, or a clock edge with enable low. A wrong shift count or a wrong frame mux shows within the frame as bits that differ from the expected word when sampled on the falling edges, or as an enable fall in the middle of a frame. A handshake fault shows on the cycle after acceptance, or later as an extra frame in the window.

// File: rtl/dac_host_pkg.sv
`timescale 1ns/1ps
package dac_host_pkg;

    localparam int unsigned CODE_W  = 8;
    localparam int unsigned CHAN_W  = 2;
    localparam int unsigned NUM_CH  = 4;
    localparam int unsigned FRAME_W = 12;

    typedef enum logic [1:0] {
        OP_CHAN   = 2'd0,
        OP_CTRL   = 2'd1,
        OP_SYNC   = 2'd2,
        OP_COMMIT = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_WINDOW,
        ST_GAP
    } seq_state_e;

    // Whole system cycles covering a time in ns, rounded up.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_host_framer.sv
`timescale 1ns/1ps
module dac_host_framer
    import dac_host_pkg::*;
(
    input  op_e                 op,
    input  logic [CHAN_W-1:0]   chan,
    input  logic [CODE_W-1:0]   code,
    input  logic [NUM_CH-1:0]   rng,
    input  logic [NUM_CH-1:0]   inh,
    input  logic                act,
    input  logic                mode,
    output logic [FRAME_W-1:0]  frame
);

    localparam int unsigned CH_PAD   = FRAME_W - 1 - CHAN_W - CODE_W;
    localparam int unsigned RNG_TOP  = FRAME_W - 2;
    localparam int unsigned INH_TOP  = RNG_TOP - NUM_CH;
    localparam int unsigned ACT_POS  = INH_TOP - NUM_CH;
    localparam int unsigned MODE_POS = ACT_POS - 1;

    logic [FRAME_W-1:0] chan_frame;
    logic [FRAME_W-1:0] ctrl_frame;

    assign chan_frame = {1'b0, chan, code, {CH_PAD{1'b0}}};

    // Channel 0 fields sit highest within each group.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ctrl_fields
        assign ctrl_frame[RNG_TOP - i] = rng[i];
        assign ctrl_frame[INH_TOP - i] = inh[i];
    end

    assign ctrl_frame[FRAME_W-1]      = 1'b1;
    assign ctrl_frame[ACT_POS]        = act;
    assign ctrl_frame[MODE_POS]       = mode;
    assign ctrl_frame[MODE_POS-1:0]   = '0;

    always_comb begin
        unique case (op)
            OP_CHAN:   frame = chan_frame;
            OP_CTRL:   frame = ctrl_frame;
            OP_SYNC:   frame = '0;
            OP_COMMIT: frame = '0;
        endcase
    end

endmodule

// File: rtl/dac_host_timer.sv
`timescale 1ns/1ps
module dac_host_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Loaded with N, expires on the N-th cycle after the load edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - CNT_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/dac_host_shifter.sv
`timescale 1ns/1ps
module dac_host_shifter #(
    parameter int unsigned FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               shift,
    output logic               msb,
    output logic               last
);

    localparam int unsigned BW = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sr;
    logic [BW-1:0]      bits_left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr        <= '0;
            bits_left <= '0;
        end else if (load) begin
            sr        <= frame_in;
            bits_left <= BW'(FRAME_W);
        end else if (shift) begin
            sr        <= {sr[FRAME_W-2:0], 1'b0};
            bits_left <= bits_left - BW'(1);
        end
    end

    assign msb  = sr[FRAME_W-1];
    assign last = (bits_left == BW'(1));

endmodule

// File: rtl/dac_serial_host.sv
`timescale 1ns/1ps
module dac_serial_host
    import dac_host_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS   = 8000,
    parameter int unsigned T_SCLK_HIGH_NS  = 400,
    parameter int unsigned T_SCLK_PER_NS   = 1000,
    parameter int unsigned T_SETUP_NS      = 50,
    parameter int unsigned T_HOLD_NS       = 50,
    parameter int unsigned T_EN_LEAD_NS    = 100,
    parameter int unsigned T_EN_LAG_NS     = 100,
    parameter int unsigned T_EN_GAP_NS     = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [1:0]  cmd_op,
    input  logic [1:0]  cmd_chan,
    input  logic [7:0]  cmd_code,
    input  logic [3:0]  cmd_range,
    input  logic [3:0]  cmd_inhibit,
    input  logic        cmd_act,
    input  logic        cmd_mode,
    output logic        dac_sclk,
    output logic        dac_sdata,
    output logic        dac_en
);

    // Derived cycle counts (R11).
    localparam int unsigned HIGH_CYC = max2(ns_to_cycles(T_SCLK_HIGH_NS, CLK_PERIOD_PS),
                                            ns_to_cycles(T_SETUP_NS, CLK_PERIOD_PS) + 1);
    localparam int unsigned LOW_CYC  = max2(ns_to_cycles(T_SCLK_PER_NS - T_SCLK_HIGH_NS, CLK_PERIOD_PS),
                                            ns_to_cycles(T_HOLD_NS, CLK_PERIOD_PS));
    localparam int unsigned LEAD_CYC = ns_to_cycles(T_EN_LEAD_NS, CLK_PERIOD_PS);
    localparam int unsigned LAG_CYC  = ns_to_cycles(T_EN_LAG_NS, CLK_PERIOD_PS);
    localparam int unsigned TAIL_CYC = max2(LOW_CYC, LAG_CYC);
    localparam int unsigned GAP_CYC  = ns_to_cycles(T_EN_GAP_NS, CLK_PERIOD_PS);
    localparam int unsigned MAX_CYC  = max2(max2(HIGH_CYC, TAIL_CYC), max2(LEAD_CYC, GAP_CYC));
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    seq_state_e         state, state_n;
    op_e                cur_op;
    logic               pulse_only;
    logic               accept;
    logic               is_frame_op;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_expired;
    logic               sh_load;
    logic               sh_shift;
    logic               sh_msb;
    logic               sh_last;
    logic               hi_entry;
    logic [FRAME_W-1:0] frame;

    assign cur_op      = op_e'(cmd_op);
    assign is_frame_op = (cur_op != OP_COMMIT);
    assign cmd_ready   = (state == ST_IDLE) || (state == ST_WINDOW);

    dac_host_framer u_framer (
        .op    (cur_op),
        .chan  (cmd_chan),
        .code  (cmd_code),
        .rng   (cmd_range),
        .inh   (cmd_inhibit),
        .act   (cmd_act),
        .mode  (cmd_mode),
        .frame (frame)
    );

    dac_host_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dac_host_shifter #(.FRAME_W(FRAME_W)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .frame_in (frame),
        .shift    (sh_shift),
        .msb      (sh_msb),
        .last     (sh_last)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pulse_only <= 1'b0;
        end else begin
            state <= state_n;
            if (accept && state == ST_IDLE) begin
                pulse_only <= !is_frame_op;
            end
        end
    end

    // Next state and datapath controls.
    always_comb begin
        state_n  = state;
        accept   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    accept   = 1'b1;
                    sh_load  = is_frame_op;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(LEAD_CYC);
                    state_n  = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (pulse_only) begin
                        tmr_val = CNT_W'(GAP_CYC);
                        state_n = ST_GAP;
                    end else begin
                        tmr_val = CNT_W'(HIGH_CYC);
                        state_n = ST_HIGH;
                    end
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (sh_last) begin
                        tmr_val = CNT_W'(TAIL_CYC);
                        state_n = ST_TAIL;
                    end else begin
                        sh_shift = 1'b1;
                        tmr_val  = CNT_W'(LOW_CYC);
                        state_n  = ST_LOW;
                    end
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HIGH_CYC);
                    state_n  = ST_HIGH;
                end
            end
            ST_TAIL: begin
                if (tmr_expired) begin
                    state_n = ST_WINDOW;
                end
            end
            ST_WINDOW: begin
                if (cmd_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (is_frame_op) begin
                        sh_load = 1'b1;
                        tmr_val = CNT_W'(HIGH_CYC);
                        state_n = ST_HIGH;
                    end else begin
                        tmr_val = CNT_W'(GAP_CYC);
                        state_n = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Registered outputs, decoded from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_en    <= 1'b0;
            dac_sclk  <= 1'b0;
            dac_sdata <= 1'b0;
            hi_entry  <= 1'b0;
        end else begin
            dac_en    <= (state_n == ST_LEAD) || (state_n == ST_HIGH) ||
                         (state_n == ST_LOW)  || (state_n == ST_TAIL) ||
                         (state_n == ST_WINDOW);
            dac_sclk  <= (state_n == ST_HIGH);
            hi_entry  <= (state_n == ST_HIGH) && (state != ST_HIGH);
            if (hi_entry) begin
                dac_sdata <= sh_msb;
            end
        end
    end

endmodule

// File: rtl/dac_serial_host_chk.sv
`timescale 1ns/1ps
module dac_serial_host_chk #(
    parameter int unsigned HIGH_CYC = 50,
    parameter int unsigned GAP_CYC  = 25
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic dac_sclk,
    input logic dac_sdata,
    input logic dac_en
);

    logic [15:0] hi_cnt;
    logic [15:0] lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '1;
        end else begin
            hi_cnt <= dac_sclk ? hi_cnt + 16'd1 : 16'd0;
            if (dac_en) begin
                lo_cnt <= '0;
            end else if (lo_cnt != '1) begin
                lo_cnt <= lo_cnt + 16'd1;
            end
        end
    end

    assert_sclk_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sclk) |-> (hi_cnt == 16'(HIGH_CYC)));

    assert_data_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_sclk && !$past(dac_sclk)) |-> $stable(dac_sdata));

    assert_sclk_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sclk |-> dac_en);

    assert_en_fall_clk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_en) |-> (!dac_sclk && !$past(dac_sclk)));

    assert_en_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_en) |-> (lo_cnt >= 16'(GAP_CYC)));

    assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !dac_sclk);

    assert_ready_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

endmodule

bind dac_serial_host dac_serial_host_chk #(
    .HIGH_CYC (HIGH_CYC),
    .GAP_CYC  (GAP_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .dac_sclk  (dac_sclk),
    .dac_sdata (dac_sdata),
    .dac_en    (dac_en)
);

// File: tb/tb_dac_serial_host.sv
`timescale 1ns/1ps
module tb_dac_serial_host;

    // Expected counts at 8 ns: ceil(400/8)=50, ceil(600/8)=75,
    // ceil(100/8)=13, tail max(75,13)=75, ceil(200/8)=25.
    localparam int EXP_HIGH = 50;
    localparam int EXP_LOW  = 75;
    localparam int EXP_LEAD = 13;
    localparam int EXP_TAIL = 75;
    localparam int EXP_GAP  = 25;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic       cmd_ready;
    logic [1:0] cmd_op;
    logic [1:0] cmd_chan;
    logic [7:0] cmd_code;
    logic [3:0] cmd_range;
    logic [3:0] cmd_inhibit;
    logic       cmd_act;
    logic       cmd_mode;
    logic       dac_sclk;
    logic       dac_sdata;
    logic       dac_en;

    always #4 clk = ~clk;

    dac_serial_host dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_code(cmd_code),
        .cmd_range(cmd_range), .cmd_inhibit(cmd_inhibit), .cmd_act(cmd_act),
        .cmd_mode(cmd_mode), .dac_sclk(dac_sclk), .dac_sdata(dac_sdata),
        .dac_en(dac_en)
    );

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    // Port monitor state.
    int          cyc = 0;
    logic        p_sclk = 1'b0, p_en = 1'b0, p_data = 1'b0;
    int          t_rise = 0, t_fall = 0, t_en_rise = 0, t_en_fall = 0;
    bit          seen_en_fall = 1'b0, first_in_win = 1'b0, fall_in_win = 1'b0;
    int          bitcnt = 0, rx_at_rise = 0;
    logic [11:0] shreg = '0;
    logic [11:0] rx_frames [0:63];
    int          rx_n = 0;
    int          win_frames [0:31];
    int          win_hi [0:31];
    int          win_n = 0;
    int v_hi = 0, v_lo = 0, v_data = 0, v_lead = 0, v_lag = 0;
    int v_gap = 0, v_outside = 0, v_partial = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (dac_sdata !== p_data) begin
                if (!(dac_sclk && p_sclk) || (cyc - t_rise != 1)) v_data++;
            end
            if (dac_en && !p_en) begin
                if (seen_en_fall && (cyc - t_en_fall < EXP_GAP)) v_gap++;
                t_en_rise    = cyc;
                first_in_win = 1'b1;
                fall_in_win  = 1'b0;
                rx_at_rise   = rx_n;
            end
            if (dac_sclk && !p_sclk) begin
                if (!dac_en) v_outside++;
                if (first_in_win) begin
                    if (cyc - t_en_rise != EXP_LEAD) v_lead++;
                    first_in_win = 1'b0;
                end else if (bitcnt != 0 && (cyc - t_fall != EXP_LOW)) begin
                    v_lo++;
                end
                t_rise = cyc;
            end
            if (!dac_sclk && p_sclk) begin
                if (cyc - t_rise != EXP_HIGH) v_hi++;
                shreg = {shreg[10:0], dac_sdata};
                bitcnt++;
                if (bitcnt == 12) begin
                    rx_frames[rx_n] = shreg;
                    rx_n++;
                    bitcnt = 0;
                end
                t_fall      = cyc;
                fall_in_win = 1'b1;
            end
            if (!dac_en && p_en) begin
                if (fall_in_win && (cyc - t_fall < EXP_TAIL)) v_lag++;
                if (bitcnt != 0) v_partial++;
                win_frames[win_n] = rx_n - rx_at_rise;
                win_hi[win_n]     = cyc - t_en_rise;
                win_n++;
                t_en_fall    = cyc;
                seen_en_fall = 1'b1;
            end
        end
        p_sclk = dac_sclk;
        p_en   = dac_en;
        p_data = dac_sdata;
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [11:0] chan_word(input logic [1:0] ch, input logic [7:0] code);
        return {1'b0, ch, code, 1'b0};
    endfunction

    function automatic logic [11:0] ctrl_word(input logic [3:0] r, input logic [3:0] s,
                                              input logic a, input logic m);
        return {1'b1, r[0], r[1], r[2], r[3], s[0], s[1], s[2], s[3], a, m, 1'b0};
    endfunction

    task automatic issue(input logic [1:0] op, input logic [1:0] ch, input logic [7:0] code,
                         input logic [3:0] r, input logic [3:0] s, input logic a,
                         input logic m);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_op      = op;
        cmd_chan    = ch;
        cmd_code    = code;
        cmd_range   = r;
        cmd_inhibit = s;
        cmd_act     = a;
        cmd_mode    = m;
        @(negedge clk);
        cmd_valid   = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(cmd_ready && !dac_en)) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(dac_en == 1'b0,    "R1 en after reset",    dac_en, 0);
        chk(dac_sclk == 1'b0,  "R1 sclk after reset",  dac_sclk, 0);
        chk(dac_sdata == 1'b0, "R1 data after reset",  dac_sdata, 0);
        chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    endtask

    task automatic t_single();
        int b = rx_n;
        int w = win_n;
        issue(2'd0, 2'd2, 8'hA5, 4'h0, 4'h0, 1'b0, 1'b0);
        issue(2'd3, 2'd0, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0);
        wait_idle();
        chk(rx_frames[b] == chan_word(2'd2, 8'hA5), "R2 channel frame",
            rx_frames[b], chan_word(2'd2, 8'hA5));
        chk(win_frames[w] == 1, "R7 single frame window", win_frames[w], 1);
    endtask

    task automatic t_batch();
        int b = rx_n;
        int w = win_n;
        issue(2'd0, 2'd0, 8'h01, 4'h0, 4'h0, 1'b0, 1'b0);
        issue(2'd0, 2'd3, 8'hFF, 4'h0, 4'h0, 1'b0, 1'b0);
        issue(2'd0, 2'd1, 8'h80, 4'h0, 4'h0, 1'b0, 1'b0);
        issue(2'd3, 2'd0, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0);
        wait_idle();
        chk(rx_frames[b]   == chan_word(2'd0, 8'h01), "R2 batch frame 0", rx_frames[b],   chan_word(2'd0, 8'h01));
        chk(rx_frames[b+1] == chan_word(2'd3, 8'hFF), "R2 batch frame 1", rx_frames[b+1], chan_word(2'd3, 8'hFF));
        chk(rx_frames[b+2] == chan_word(2'd1, 8'h80), "R2 batch frame 2", rx_frames[b+2], chan_word(2'd1, 8'h80));
        chk(win_n == w + 1, "R7 one window for batch", win_n - w, 1);
        chk(win_frames[w] == 3, "R7 frames in batch window", win_frames[w], 3);
    endtask

    task automatic t_ctrl();
        int b = rx_n;
        issue(2'd1, 2'd0, 8'h00, 4'b0101, 4'b1100, 1'b1, 1'b0);
        issue(2'd1, 2'd0, 8'h00, 4'b1010, 4'b0011, 1'b0, 1'b1);
        issue(2'd3, 2'd0, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0);
        wait_idle();
        chk(rx_frames[b] == ctrl_word(4'b0101, 4'b1100, 1'b1, 1'b0), "R3 control frame a",
            rx_frames[b], ctrl_word(4'b0101, 4'b1100, 1'b1, 1'b0));
        chk(rx_frames[b+1] == ctrl_word(4'b1010, 4'b0011, 1'b0, 1'b1), "R3 control frame b",
            rx_frames[b+1], ctrl_word(4'b1010, 4'b0011, 1'b0, 1'b1));
    endtask

    task automatic t_sync();
        int b = rx_n;
        int w = win_n;
        issue(2'd2, 2'd3, 8'hFF, 4'hF, 4'hF, 1'b1, 1'b1);
        issue(2'd3, 2'd0, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0);
        wait_idle();
        chk(rx_frames[b] == 12'h000, "R4 resync frame", rx_frames[b], 0);
        chk(win_frames[w] == 1, "R4 resync window count", win_frames[w], 1);
    endtask

    task automatic t_pulse();
        int b = rx_n;
        int w = win_n;
        issue(2'd3, 2'd0, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0);
        wait_idle();
        chk(win_frames[w] == 0, "R8 bare commit has no frames", win_frames[w], 0);
        chk(win_hi[w] == EXP_LEAD, "R8 bare commit pulse width", win_hi[w], EXP_LEAD);
        chk(rx_n == b, "R8 no clock edges", rx_n - b, 0);
    endtask

    task automatic t_busy();
        int b = rx_n;
        int w = win_n;
        issue(2'd0, 2'd1, 8'h3C, 4'h0, 4'h0, 1'b0, 1'b0);
        chk(cmd_ready == 1'b0, "R10 ready low after accept", cmd_ready, 0);
        cmd_valid = 1'b1;
        cmd_op    = 2'd0;
        cmd_chan  = 2'd3;
        cmd_code  = 8'hAA;
        repeat (300) @(negedge clk);
        chk(cmd_ready == 1'b0, "R10 ready low while shifting", cmd_ready, 0);
        cmd_valid = 1'b0;
        issue(2'd3, 2'd0, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0);
        wait_idle();
        chk(win_frames[w] == 1, "R10 busy request ignored", win_frames[w], 1);
        chk(rx_frames[b] == chan_word(2'd1, 8'h3C), "R10 frame unchanged",
            rx_frames[b], chan_word(2'd1, 8'h3C));
    endtask

    task automatic t_timing();
        chk(v_hi == 0,      "R5 R11 sclk high width",       v_hi, 0);
        chk(v_lo == 0,      "R5 R11 sclk low width",        v_lo, 0);
        chk(v_data == 0,    "R5 data change placement",     v_data, 0);
        chk(v_lead == 0,    "R6 enable lead",               v_lead, 0);
        chk(v_lag == 0,     "R6 enable lag after last bit", v_lag, 0);
        chk(v_outside == 0, "R7 clock outside window",      v_outside, 0);
        chk(v_partial == 0, "R7 enable fall mid-frame",     v_partial, 0);
        chk(v_gap == 0,     "R9 enable low gap",            v_gap, 0);
    endtask

    initial begin
        rst_n       = 1'b0;
        cmd_valid   = 1'b0;
        cmd_op      = 2'd0;
        cmd_chan    = 2'd0;
        cmd_code    = 8'h00;
        cmd_range   = 4'h0;
        cmd_inhibit = 4'h0;
        cmd_act     = 1'b0;
        cmd_mode    = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_batch();
        t_ctrl();
        t_sync();
        t_pulse();
        t_busy();
        t_timing();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule